// File: doc/BRIEF.md
# Two-Wire Serial Data Buffer Flag Controller

This block owns the byte path of a two-wire serial port. The path has three registers. The CPU writes outgoing bytes into a transmit holding register. A single shift register exchanges bytes with the bit-level shifter. Incoming bytes wait in a receive holding register for the CPU to read them. The block produces two status flags. The transmit-empty flag tells software that it may write the next outgoing byte. The receive-full flag tells software that a received byte is ready to read.

The flags respond to more than CPU accesses. The transmit-empty flag is also driven by bus start and stop events, by whether this port issued those conditions, by mode changes, and by the selected framing. The selected framing is an I2C-style bus, a clocked serial link, or a raw formatless stream. Bit shifting, arbitration and interrupts belong to neighbouring blocks. This block only sees a frame-complete pulse and a good-termination flag from the shifter, together with the byte that the shifter assembled.

Top module: `twb_buf_top`

## Requirements
- R1: After reset, txFlag and rxFlag are 0 and txShiftData and cpuRdData are all zeros.
- R2: A cpuWr while the effective mode is transmit captures cpuWrData and clears txFlag at that clock edge. If the same cycle also has a set condition, the clear wins and the flag may set again on a later cycle.
- R3: The effective mode follows trsIn through one register. txFlag is forced to 0 on every edge at which the effective mode is receive.
- R4: If trsIn drops to 0 while busy is 1, the effective mode stays transmit until the edge that samples shiftDone. It then takes the value of trsIn.
- R5: fmtSel encodes 0 = I2C, 1 = clocked serial, 2 or 3 = formatless. In transmit mode, busStopSeen clears txFlag in the following cases:
  - with I2C, always;
  - with clocked serial, only when a stopIssued pulse came in an earlier cycle and no bus stop has been seen since;
  - with formatless, never.
- R6: In transmit mode, with isMaster = 1 and I2C or clocked-serial format, busStartSeen sets txFlag when a startIssued pulse came in an earlier cycle and is still outstanding.
- R7: With formatless framing and transmit mode, txFlag is set on every edge that has no clearing access.
- R8: In transmit mode, a held byte moves into the shift register when the shift register is empty, and txFlag sets on that edge. The shift register is empty when it is not loaded and has no pending receive byte. A loaded shift register is emptied by shiftDone.
- R9: In receive mode, a shiftDone with shiftOk = 1 and rxFlag = 0 copies rxByte into the receive holding register and sets rxFlag. A shiftDone with shiftOk = 0 changes neither.
- R10: cpuRd in receive mode clears rxFlag. cpuRd in transmit mode leaves rxFlag and cpuRdData unchanged.
- R11: A good frame that completes while rxFlag = 1, or in the same cycle as a clearing read, waits in the shift register. It moves to the receive holding register, setting rxFlag, one edge after rxFlag reads 0.
- R12: Changing from receive to transmit sets txFlag on the first transmit cycle when a bus start has been seen since the last bus stop. Otherwise the change leaves txFlag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWr | input | 1 | CPU write strobe to the transmit holding register |
| cpuWrData | input | DATA_W | CPU write data |
| cpuRd | input | 1 | CPU read strobe of the receive holding register |
| cpuRdData | output | DATA_W | Receive holding register contents |
| trsIn | input | 1 | Requested direction, 1 = transmit |
| busy | input | 1 | A frame is in progress on the bus |
| isMaster | input | 1 | Port acts as bus master |
| fmtSel | input | 2 | Framing select (see R5) |
| busStartSeen | input | 1 | Start condition detected on the bus |
| busStopSeen | input | 1 | Stop condition detected on the bus |
| startIssued | input | 1 | This port issued a start condition |
| stopIssued | input | 1 | This port issued a stop condition |
| shiftDone | input | 1 | Shifter finished a frame |
| shiftOk | input | 1 | Frame ended normally |
| rxByte | input | DATA_W | Byte assembled by the shifter |
| txShiftData | output | DATA_W | Shift register contents |
| txFlag | output | 1 | Transmit holding register may be written |
| rxFlag | output | 1 | Receive holding register holds unread data |

## Verification
The hardest state to reach is a received byte parked in the shift register. To get there, a good frame must end while rxFlag is still set, or in the same cycle as the read that clears it. The bench must then confirm that the parked byte reaches cpuRdData exactly one edge after the flag drops. Directed sequences produce both timings. The random phase fires frame-complete and read pulses at rates high enough to make them collide often. It also toggles the mode while busy is held, which exercises the deferred drop to receive.

// File: rtl/twb_pkg.sv
package twb_pkg;

  localparam logic [1:0] FMT_I2C    = 2'd0;
  localparam logic [1:0] FMT_CLKSER = 2'd1;

  // Strobes from the flag control to the byte registers
  typedef struct packed {
    logic ldHold;          // CPU byte into holding register
    logic ldShiftFromHold; // holding register into shift register
    logic ldShiftFromBus;  // received byte parked in shift register
    logic ldRxFromShift;   // parked byte into receive register
    logic ldRxFromBus;     // received byte straight into receive register
  } dpStrobe_t;

endpackage

// File: rtl/twb_flag_ctrl.sv
module twb_flag_ctrl
  import twb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWr,
  input  logic       cpuRd,
  input  logic       trsIn,
  input  logic       busy,
  input  logic       isMaster,
  input  logic [1:0] fmtSel,
  input  logic       busStartSeen,
  input  logic       busStopSeen,
  input  logic       startIssued,
  input  logic       stopIssued,
  input  logic       shiftDone,
  input  logic       shiftOk,
  output logic       txFlag,
  output logic       rxFlag,
  output dpStrobe_t  strobe
);

  logic trsEff, trsEffD;
  logic holdValid, txShiftFull, rxPending;
  logic startPend, stopPend, busOn;
  logic tdreQ, rdrfQ;

  logic isRaw, isI2c, isFramed;
  logic trsKeep, trsNext;
  logic wrTx, rdRx, frameRx, movePend, directRx, loadHold;
  logic stopClr, startSet, txEnter, tdreSet;
  logic tdreNext, rdrfNext;

  assign isRaw    = fmtSel[1];
  assign isFramed = ~fmtSel[1];
  assign isI2c    = (fmtSel == FMT_I2C);

  // Deferred drop to receive while a frame is on the bus
  assign trsKeep = trsEff & ~trsIn & busy & ~shiftDone;
  assign trsNext = trsKeep ? 1'b1 : trsIn;

  assign wrTx     = trsEff & cpuWr;
  assign rdRx     = ~trsEff & cpuRd;
  assign frameRx  = ~trsEff & shiftDone & shiftOk;
  assign movePend = rxPending & ~rdrfQ & ~rdRx;
  assign directRx = frameRx & ~rdrfQ & ~rxPending & ~rdRx;
  assign loadHold = trsEff & holdValid & ~txShiftFull & ~rxPending;

  assign stopClr  = busStopSeen & (isI2c | (isFramed & stopPend));
  assign startSet = isMaster & isFramed & busStartSeen & startPend;
  assign txEnter  = trsEff & ~trsEffD & busOn;
  assign tdreSet  = startSet | isRaw | loadHold | txEnter;

  always_comb begin
    if (!trsEff)       tdreNext = 1'b0;
    else if (wrTx)     tdreNext = 1'b0;
    else if (stopClr)  tdreNext = 1'b0;
    else if (tdreSet)  tdreNext = 1'b1;
    else               tdreNext = tdreQ;
  end

  always_comb begin
    if (rdRx)                       rdrfNext = 1'b0;
    else if (movePend || directRx)  rdrfNext = 1'b1;
    else                            rdrfNext = rdrfQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trsEff      <= 1'b0;
      trsEffD     <= 1'b0;
      holdValid   <= 1'b0;
      txShiftFull <= 1'b0;
      rxPending   <= 1'b0;
      startPend   <= 1'b0;
      stopPend    <= 1'b0;
      busOn       <= 1'b0;
      tdreQ       <= 1'b0;
      rdrfQ       <= 1'b0;
    end else begin
      trsEff  <= trsNext;
      trsEffD <= trsEff;
      tdreQ   <= tdreNext;
      rdrfQ   <= rdrfNext;

      if (!trsEff)       holdValid <= 1'b0;
      else if (wrTx)     holdValid <= 1'b1;
      else if (loadHold) holdValid <= 1'b0;

      if (!trsEff)        txShiftFull <= 1'b0;
      else if (loadHold)  txShiftFull <= 1'b1;
      else if (shiftDone) txShiftFull <= 1'b0;

      if (frameRx && !directRx) rxPending <= 1'b1;
      else if (movePend)        rxPending <= 1'b0;

      if (startIssued)       startPend <= 1'b1;
      else if (busStartSeen) startPend <= 1'b0;

      if (stopIssued)       stopPend <= 1'b1;
      else if (busStopSeen) stopPend <= 1'b0;

      if (busStartSeen)     busOn <= 1'b1;
      else if (busStopSeen) busOn <= 1'b0;
    end
  end

  always_comb begin
    strobe                 = '0;
    strobe.ldHold          = wrTx;
    strobe.ldShiftFromHold = loadHold;
    strobe.ldShiftFromBus  = frameRx & ~directRx;
    strobe.ldRxFromShift   = movePend;
    strobe.ldRxFromBus     = directRx;
  end

  assign txFlag = tdreQ;
  assign rxFlag = rdrfQ;

  // R3
  tdre_rx_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trsEff |=> !txFlag);

  // R2
  tdre_write_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trsEff && cpuWr) |=> !txFlag);

  // R10
  rdrf_read_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trsEff && cpuRd) |=> !rxFlag);

  // R9
  rdrf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && !(cpuRd && !trsEff)) |=> rxFlag);

  // R4
  trs_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trsEff && busy && !shiftDone) |=> trsEff);

endmodule

// File: rtl/twb_byte_path.sv
module twb_byte_path
  import twb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] txShiftData,
  output logic [DATA_W-1:0] cpuRdData
);

  logic [DATA_W-1:0] holdReg, shiftReg, rxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
      rxReg    <= '0;
    end else begin
      if (strobe.ldHold) holdReg <= cpuWrData;

      if (strobe.ldShiftFromHold)     shiftReg <= holdReg;
      else if (strobe.ldShiftFromBus) shiftReg <= rxByte;

      if (strobe.ldRxFromShift)    rxReg <= shiftReg;
      else if (strobe.ldRxFromBus) rxReg <= rxByte;
    end
  end

  assign txShiftData = shiftReg;
  assign cpuRdData   = rxReg;

  // R8
  hold_to_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldShiftFromHold |=> (shiftReg == $past(holdReg)));

  // R11
  shift_to_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldRxFromShift |=> (rxReg == $past(shiftReg)));

  // R10
  rx_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.ldRxFromShift || strobe.ldRxFromBus) |=> $stable(rxReg));

endmodule

// File: rtl/twb_buf_top.sv
module twb_buf_top
  import twb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRd,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              trsIn,
  input  logic              busy,
  input  logic              isMaster,
  input  logic [1:0]        fmtSel,
  input  logic              busStartSeen,
  input  logic              busStopSeen,
  input  logic              startIssued,
  input  logic              stopIssued,
  input  logic              shiftDone,
  input  logic              shiftOk,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] txShiftData,
  output logic              txFlag,
  output logic              rxFlag
);

  dpStrobe_t strobe;

  twb_flag_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuWr        (cpuWr),
    .cpuRd        (cpuRd),
    .trsIn        (trsIn),
    .busy         (busy),
    .isMaster     (isMaster),
    .fmtSel       (fmtSel),
    .busStartSeen (busStartSeen),
    .busStopSeen  (busStopSeen),
    .startIssued  (startIssued),
    .stopIssued   (stopIssued),
    .shiftDone    (shiftDone),
    .shiftOk      (shiftOk),
    .txFlag       (txFlag),
    .rxFlag       (rxFlag),
    .strobe       (strobe)
  );

  twb_byte_path #(.DATA_W(DATA_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cpuWrData   (cpuWrData),
    .rxByte      (rxByte),
    .txShiftData (txShiftData),
    .cpuRdData   (cpuRdData)
  );

endmodule

// File: tb/tb_twb_buf_top.sv
module tb_twb_buf_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, cpuWr, cpuRd, trsIn, busy, isMaster;
  logic busStartSeen, busStopSeen, startIssued, stopIssued, shiftDone, shiftOk;
  logic [1:0] fmtSel;
  logic [DW-1:0] cpuWrData, rxByte, cpuRdData, txShiftData;
  logic txFlag, rxFlag;

  int checkCnt = 0;
  int errCnt = 0;

  twb_buf_top #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuWrData(cpuWrData),
    .cpuRd(cpuRd), .cpuRdData(cpuRdData), .trsIn(trsIn), .busy(busy),
    .isMaster(isMaster), .fmtSel(fmtSel), .busStartSeen(busStartSeen),
    .busStopSeen(busStopSeen), .startIssued(startIssued),
    .stopIssued(stopIssued), .shiftDone(shiftDone), .shiftOk(shiftOk),
    .rxByte(rxByte), .txShiftData(txShiftData), .txFlag(txFlag),
    .rxFlag(rxFlag)
  );

  // Reference model state (post-edge values)
  logic mTrs, mTrsD, mTdre, mRdrf, mHoldV, mTxFull, mRxPend;
  logic mStartP, mStopP, mBusOn;
  logic [DW-1:0] mHold, mShift, mRx;

  task automatic modelReset();
    mTrs = 0; mTrsD = 0; mTdre = 0; mRdrf = 0; mHoldV = 0; mTxFull = 0;
    mRxPend = 0; mStartP = 0; mStopP = 0; mBusOn = 0;
    mHold = '0; mShift = '0; mRx = '0;
  endtask

  // Next state from the requirement rules and the current inputs
  task automatic modelStep();
    logic raw, i2c, wr, rd, frm, mv, dir, ld, clr, set;
    logic nTrs, nTdre, nRdrf, nHoldV, nTxFull, nRxPend;
    logic [DW-1:0] nHold, nShift, nRx;
    raw = fmtSel[1];
    i2c = (fmtSel == 2'd0);
    wr  = mTrs && cpuWr;
    rd  = !mTrs && cpuRd;
    frm = !mTrs && shiftDone && shiftOk;
    mv  = mRxPend && !mRdrf && !rd;
    dir = frm && !mRdrf && !mRxPend && !rd;
    ld  = mTrs && mHoldV && !mTxFull && !mRxPend;
    clr = busStopSeen && (i2c || (!raw && mStopP));
    set = (isMaster && !raw && busStartSeen && mStartP) || raw || ld ||
          (mTrs && !mTrsD && mBusOn);
    nTrs = (mTrs && !trsIn && busy && !shiftDone) ? 1'b1 : trsIn;
    if (!mTrs || wr || clr) nTdre = 0; else if (set) nTdre = 1; else nTdre = mTdre;
    if (rd) nRdrf = 0; else if (mv || dir) nRdrf = 1; else nRdrf = mRdrf;
    if (!mTrs) nHoldV = 0; else if (wr) nHoldV = 1; else if (ld) nHoldV = 0; else nHoldV = mHoldV;
    if (!mTrs) nTxFull = 0; else if (ld) nTxFull = 1; else if (shiftDone) nTxFull = 0; else nTxFull = mTxFull;
    if (frm && !dir) nRxPend = 1; else if (mv) nRxPend = 0; else nRxPend = mRxPend;
    nHold = wr ? cpuWrData : mHold;
    nShift = ld ? mHold : ((frm && !dir) ? rxByte : mShift);
    nRx = mv ? mShift : (dir ? rxByte : mRx);
    if (startIssued) mStartP = 1; else if (busStartSeen) mStartP = 0;
    if (stopIssued) mStopP = 1; else if (busStopSeen) mStopP = 0;
    if (busStartSeen) mBusOn = 1; else if (busStopSeen) mBusOn = 0;
    mTrsD = mTrs; mTrs = nTrs; mTdre = nTdre; mRdrf = nRdrf; mHoldV = nHoldV;
    mTxFull = nTxFull; mRxPend = nRxPend; mHold = nHold; mShift = nShift; mRx = nRx;
  endtask

  task automatic clearPulses();
    cpuWr = 0; cpuRd = 0; busStartSeen = 0; busStopSeen = 0;
    startIssued = 0; stopIssued = 0; shiftDone = 0;
  endtask

  task automatic tick();
    modelStep();
    @(negedge clk);
    clearPulses();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expectVal(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    expectVal({tag, " txFlag"}, {7'd0, txFlag}, {7'd0, mTdre});
    expectVal({tag, " rxFlag"}, {7'd0, rxFlag}, {7'd0, mRdrf});
    expectVal({tag, " txShiftData"}, txShiftData, mShift);
    expectVal({tag, " cpuRdData"}, cpuRdData, mRx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    clearPulses();
    rstN = 0; trsIn = 0; busy = 0; isMaster = 1; fmtSel = 2'd0; shiftOk = 1;
    cpuWrData = '0; rxByte = '0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    expectVal("R1 txFlag", {7'd0, txFlag}, 8'd0);
    expectVal("R1 rxFlag", {7'd0, rxFlag}, 8'd0);
    expectVal("R1 txShiftData", txShiftData, 8'd0);
    expectVal("R1 cpuRdData", cpuRdData, 8'd0);

    // R6 master start after issue, I2C
    trsIn = 1; ticks(3); chkAll("R6");
    startIssued = 1; tick(); busStartSeen = 1; tick();
    expectVal("R6 start sets", {7'd0, txFlag}, 8'd1); chkAll("R6");

    // R2 / R8 write then transfer
    cpuWr = 1; cpuWrData = 8'hA5; tick();
    expectVal("R2 write clears", {7'd0, txFlag}, 8'd0);
    tick();
    expectVal("R8 load sets", {7'd0, txFlag}, 8'd1);
    expectVal("R8 shift byte", txShiftData, 8'hA5);
    cpuWr = 1; cpuWrData = 8'h3C; tick(); ticks(2);
    expectVal("R8 waits full", {7'd0, txFlag}, 8'd0);
    shiftDone = 1; tick(); tick();
    expectVal("R8 reload", txShiftData, 8'h3C);
    expectVal("R8 reload flag", {7'd0, txFlag}, 8'd1); chkAll("R8");

    // R5 I2C: any stop clears
    busStopSeen = 1; tick();
    expectVal("R5 i2c stop", {7'd0, txFlag}, 8'd0);
    // R5 clocked serial: only after stop issue
    fmtSel = 2'd1; startIssued = 1; tick(); busStartSeen = 1; tick();
    expectVal("R6 clkser start", {7'd0, txFlag}, 8'd1);
    busStopSeen = 1; tick();
    expectVal("R5 clkser foreign stop", {7'd0, txFlag}, 8'd1);
    stopIssued = 1; tick(); busStopSeen = 1; tick();
    expectVal("R5 clkser own stop", {7'd0, txFlag}, 8'd0);

    // R7 formatless
    fmtSel = 2'd2; tick();
    expectVal("R7 formatless set", {7'd0, txFlag}, 8'd1);
    busStopSeen = 1; tick();
    expectVal("R5 formatless stop", {7'd0, txFlag}, 8'd1);
    cpuWr = 1; cpuWrData = 8'h11; tick();
    expectVal("R2 clear wins", {7'd0, txFlag}, 8'd0);
    tick();
    expectVal("R7 re-set", {7'd0, txFlag}, 8'd1); chkAll("R7");

    // R4 deferred drop
    busy = 1; trsIn = 0; ticks(3);
    expectVal("R4 deferred", {7'd0, txFlag}, 8'd1);
    shiftDone = 1; tick(); tick();
    expectVal("R4 drop after frame", {7'd0, txFlag}, 8'd0);
    busy = 0; chkAll("R3");

    // R9 / R11 / R10 receive
    fmtSel = 2'd0; ticks(2);
    expectVal("R3 rx zero", {7'd0, txFlag}, 8'd0);
    shiftDone = 1; shiftOk = 1; rxByte = 8'h81; tick();
    expectVal("R9 rx set", {7'd0, rxFlag}, 8'd1);
    expectVal("R9 rx byte", cpuRdData, 8'h81);
    shiftDone = 1; shiftOk = 0; rxByte = 8'h22; tick();
    expectVal("R9 bad frame", cpuRdData, 8'h81);
    shiftDone = 1; shiftOk = 1; rxByte = 8'h55; tick();
    expectVal("R11 parked", cpuRdData, 8'h81);
    cpuRd = 1; tick();
    expectVal("R10 read clears", {7'd0, rxFlag}, 8'd0);
    tick();
    expectVal("R11 moved flag", {7'd0, rxFlag}, 8'd1);
    expectVal("R11 moved byte", cpuRdData, 8'h55);
    // read and frame in the same cycle
    cpuRd = 1; shiftDone = 1; rxByte = 8'h66; tick();
    expectVal("R11 clear wins", {7'd0, rxFlag}, 8'd0);
    tick();
    expectVal("R11 late move", cpuRdData, 8'h66); chkAll("R11");

    // R12 no start seen: switch leaves flag 0
    busStopSeen = 1; tick(); trsIn = 1; ticks(3);
    expectVal("R12 no start", {7'd0, txFlag}, 8'd0);
    // R10 read in transmit mode does nothing
    cpuRd = 1; tick();
    expectVal("R10 tx read", {7'd0, rxFlag}, 8'd1);
    // R12 with start seen
    trsIn = 0; ticks(2); busStartSeen = 1; tick();
    trsIn = 1; ticks(2);
    expectVal("R12 switch sets", {7'd0, txFlag}, 8'd1); chkAll("R12");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 6) trsIn = ~trsIn;
      if ($urandom_range(0, 99) < 3) fmtSel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) < 10) busy = ~busy;
      if ($urandom_range(0, 99) < 5) isMaster = ~isMaster;
      cpuWr = ($urandom_range(0, 99) < 25);
      cpuRd = ($urandom_range(0, 99) < 25);
      busStartSeen = ($urandom_range(0, 99) < 8);
      busStopSeen = ($urandom_range(0, 99) < 6);
      startIssued = ($urandom_range(0, 99) < 8);
      stopIssued = ($urandom_range(0, 99) < 8);
      shiftDone = ($urandom_range(0, 99) < 25);
      shiftOk = ($urandom_range(0, 99) < 80);
      cpuWrData = 8'($urandom);
      rxByte = 8'($urandom);
      tick();
      expectVal("R5 random txFlag", {7'd0, txFlag}, {7'd0, mTdre});
      expectVal("R9 random rxFlag", {7'd0, rxFlag}, {7'd0, mRdrf});
      expectVal("R8 random txShiftData", txShiftData, mShift);
      expectVal("R11 random cpuRdData", cpuRdData, mRx);
    end

    $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
    $finish;
  end

endmodule